// File: doc/BRIEF.md
# EEPROM Access Control Unit

This unit connects a small CPU register bus to an on-chip byte-wide EEPROM array. The CPU sees three registers: a byte address, a data byte and a control byte. A byte is read by setting a read strobe. A byte is written by first setting a master write enable and then, within a short window, setting a write strobe.

The master enable lapses by itself. A write that is started stays busy for a programmable number of clock cycles, and software polls the write strobe bit to see when it ends. Writing the address or data register while a write is busy aborts that write. The aborted byte is left holding all ones.

Every accepted strobe asserts a CPU stall request for a fixed number of cycles. The array itself is a plain register file that reset does not clear.

Top module: `eeacc_access_ctrl`

## Requirements
- R1: Bus register select `bus_sel` 0 is the address register, 1 the data register, 2 the control register and 3 reads zero. A write takes effect at the clock edge, and `bus_rdata` shows the selected register in the same cycle. The address register keeps only its low ADDR_W bits: with ADDR_W=6, writing 0x45 reads back 0x05 and selects byte 5. Control bit 0 is the read strobe, bit 1 the write strobe and bit 2 the master write enable. Bits 7:3 read zero.
- R2: A control write with bit 1 set starts a write only if the master write enable was set by a control write 1 to 4 cycles earlier and no write is busy. A strobe 5 or more cycles after arming starts nothing. Setting bits 1 and 2 in the same write only arms.
- R3: The master write enable reads 1 during the 4 cycles after the arming write and 0 from the fifth cycle on. Starting a write also clears it.
- R4: Once started, a write keeps control bit 1 at 1 for exactly WRITE_CYCLES cycles. Hardware then clears it and stores the data byte captured at the start into the byte at the captured address.
- R5: Starting a write asserts `cpu_stall` for the 2 cycles that follow.
- R6: A control write with bit 0 set, while no write is busy, loads the addressed byte into the data register at that edge and asserts `cpu_stall` for the 4 following cycles. Control bit 0 always reads 0.
- R7: Writing the address or data register while a write is busy ends the write at that edge. The target byte becomes 0xFF and the register takes the new value.
- R8: A read strobe while a write is busy is ignored: the data register is unchanged and no stall is added. If a write starts in the same control write, the read strobe is also ignored.
- R9: Reset (synchronous, active low) clears the enable, the busy state, the address and data registers and the stall, and leaves the array contents unchanged.
- R10: A new arming and write strobe while a write is busy neither restarts nor lengthens that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Register select |
| bus_we | input | 1 | Register write enable for this cycle |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Selected register contents |
| cpu_stall | output | 1 | CPU stall request |

## Verification
The hardest situations to reach are the edges of the arming window and the disturbances of a write that is in flight. They depend on how many cycles separate two bus writes, not on the values written. The stimulus therefore places the write strobe exactly four and exactly five cycles after arming, and it arms and strobes again partway through a busy write. It also issues a data-register write and a read strobe while a write is busy. A cycle-accurate model in the bench follows every cycle, so a write that shifts by one cycle or an abort that lands on the wrong byte shows up at once.

// File: rtl/eeacc_pkg.sv
// Package: shared register-select encoding and control bit positions
// for the EEPROM access control unit.
package eeacc_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } eeacc_sel_e;

    localparam int CTRL_RD_BIT  = 0;
    localparam int CTRL_WR_BIT  = 1;
    localparam int CTRL_ARM_BIT = 2;

    localparam logic [7:0] POISON_BYTE = 8'hFF;

endpackage

// File: rtl/eeacc_countdown.sv
// Module: loadable down-counter that stops at zero.
// Assumes clear has priority over load. The counter holds at zero and
// reports its present value so the parent derives active/last flags.
module eeacc_countdown #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] cnt_o
);

    logic [WIDTH-1:0] cnt_q;

    // Purpose: clear, load or count down by one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/eeacc_byte_array.sv
// Module: byte-wide storage array standing in for the EEPROM cells.
// One synchronous write port and one combinational read port. The contents
// are deliberately not reset.
module eeacc_byte_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Purpose: store a byte when the write port is enabled.
    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[waddr_i] <= wdata_i;
        end
    end

    // Purpose: present the addressed byte without delay.
    always_comb begin
        rdata_o = cells[raddr_i];
    end

endmodule

// File: rtl/eeacc_access_ctrl.sv
// Module: EEPROM access control unit (top).
// Decodes the register bus and applies the two-step write arming window.
// Times each write, aborts a write on a register disturbance and raises a
// CPU stall after each accepted strobe. Assumes ADDR_W <= 8 and that all
// count parameters are at least 1.
module eeacc_access_ctrl
    import eeacc_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int WRITE_CYCLES = 20,
    parameter int ARM_WINDOW   = 4,
    parameter int WR_STALL     = 2,
    parameter int RD_STALL     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_sel,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       cpu_stall
);

    localparam int WT_W   = $clog2(WRITE_CYCLES + 1);
    localparam int ARM_W  = $clog2(ARM_WINDOW + 1);
    localparam int ST_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
    localparam int ST_W   = $clog2(ST_MAX + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [7:0]        wr_data_q;

    logic              ctrl_wr, arm_req, wr_start, rd_go, wr_abort, wr_commit;
    logic              arm_active, wr_busy, wr_last;
    logic [ARM_W-1:0]  arm_cnt;
    logic [WT_W-1:0]   wr_cnt;
    logic [ST_W-1:0]   st_cnt, st_load_val;
    logic              arr_we;
    logic [7:0]        arr_wdata, arr_rdata;
    eeacc_sel_e        sel;

    // Purpose: decode the bus cycle into strobe, arm and abort requests.
    always_comb begin
        sel       = eeacc_sel_e'(bus_sel);
        ctrl_wr   = bus_we && (sel == SEL_CTRL);
        arm_req   = ctrl_wr && bus_wdata[CTRL_ARM_BIT];
        wr_start  = ctrl_wr && bus_wdata[CTRL_WR_BIT] && arm_active && !wr_busy;
        rd_go     = ctrl_wr && bus_wdata[CTRL_RD_BIT] && !wr_busy && !wr_start;
        wr_abort  = bus_we && wr_busy && ((sel == SEL_ADDR) || (sel == SEL_DATA));
        wr_commit = wr_last && !wr_abort;
    end

    // Purpose: derive status flags from the counter values.
    always_comb begin
        arm_active = (arm_cnt != '0);
        wr_busy    = (wr_cnt != '0);
        wr_last    = (wr_cnt == WT_W'(1));
        cpu_stall  = (st_cnt != '0);
    end

    eeacc_countdown #(.WIDTH(ARM_W)) arm_timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (wr_start),
        .load_i     (arm_req),
        .load_val_i (ARM_W'(ARM_WINDOW)),
        .cnt_o      (arm_cnt)
    );

    eeacc_countdown #(.WIDTH(WT_W)) write_timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (wr_abort),
        .load_i     (wr_start),
        .load_val_i (WT_W'(WRITE_CYCLES)),
        .cnt_o      (wr_cnt)
    );

    // Purpose: select the stall length for the strobe being accepted.
    always_comb begin
        st_load_val = wr_start ? ST_W'(WR_STALL) : ST_W'(RD_STALL);
    end

    eeacc_countdown #(.WIDTH(ST_W)) stall_timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (1'b0),
        .load_i     (wr_start || rd_go),
        .load_val_i (st_load_val),
        .cnt_o      (st_cnt)
    );

    // Purpose: hold the CPU-visible address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (bus_we && (sel == SEL_ADDR)) begin
            addr_q <= bus_wdata[ADDR_W-1:0];
        end
    end

    // Purpose: hold the data register, loaded by the bus or by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (bus_we && (sel == SEL_DATA)) begin
            data_q <= bus_wdata;
        end else if (rd_go) begin
            data_q <= arr_rdata;
        end
    end

    // Purpose: capture the target and byte of a write when it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else if (wr_start) begin
            wr_addr_q <= addr_q;
            wr_data_q <= data_q;
        end
    end

    // Purpose: drive the array write port on completion or abort.
    always_comb begin
        arr_we    = wr_commit || wr_abort;
        arr_wdata = wr_abort ? POISON_BYTE : wr_data_q;
    end

    eeacc_byte_array #(.ADDR_W(ADDR_W)) cells_i (
        .clk     (clk),
        .we_i    (arr_we),
        .waddr_i (wr_addr_q),
        .wdata_i (arr_wdata),
        .raddr_i (addr_q),
        .rdata_o (arr_rdata)
    );

    // Purpose: return the selected register on the bus.
    always_comb begin
        unique case (sel)
            SEL_ADDR: bus_rdata = 8'(addr_q);
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = {5'b0, arm_active, wr_busy, 1'b0};
            default:  bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/eeacc_checker.sv
// Module: property checker for the EEPROM access control unit, bound to
// every instance of the top. Age counters bound the parameter-sized windows.
module eeacc_checker #(
    parameter int WRITE_CYCLES = 20,
    parameter int ARM_WINDOW   = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_sel,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic       cpu_stall,
    input logic       arm_active,
    input logic       wr_busy,
    input logic       wr_start,
    input logic [7:0] data_q
);

    logic ctrl_wr, abort_now;
    int   arm_age, busy_age;

    assign ctrl_wr   = bus_we && (bus_sel == 2'd2);
    assign abort_now = bus_we && (bus_sel < 2'd2) && wr_busy;

    // Purpose: count cycles since the last arming write that did not start a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_age <= ARM_WINDOW + 1;
        end else if (ctrl_wr && bus_wdata[2] && !wr_start) begin
            arm_age <= 1;
        end else if (arm_age <= ARM_WINDOW) begin
            arm_age <= arm_age + 1;
        end
    end

    // Purpose: count cycles since the current write started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_age <= 0;
        end else if (wr_start) begin
            busy_age <= 1;
        end else if (wr_busy) begin
            busy_age <= busy_age + 1;
        end
    end

    assert_no_unarmed_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[1] && !arm_active && !wr_busy) |=> !wr_busy);

    assert_arm_lapses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_active |-> (arm_age <= ARM_WINDOW));

    assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && !abort_now && (busy_age < WRITE_CYCLES)) |=> wr_busy);

    assert_write_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> cpu_stall ##1 cpu_stall);

    assert_read_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[0] && !wr_busy && !wr_start) |=> cpu_stall);

    assert_abort_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now |=> !wr_busy);

    assert_busy_read_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[0] && wr_busy) |=> $stable(data_q));

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (!cpu_stall && !wr_busy && !arm_active));

endmodule

bind eeacc_access_ctrl eeacc_checker #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .ARM_WINDOW   (ARM_WINDOW)
) checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .cpu_stall  (cpu_stall),
    .arm_active (arm_active),
    .wr_busy    (wr_busy),
    .wr_start   (wr_start),
    .data_q     (data_q)
);

// File: tb/eeacc_access_ctrl_tb_top.sv
// Bench: directed sequences plus a behavioural cycle model compared every clock.
module eeacc_access_ctrl_tb_top;

    localparam int WC      = 20;
    localparam int AW      = 6;
    localparam int WDOG    = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd3;
    logic       we = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       stall;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [7:0] o_rd;
    logic       o_st;

    // behavioural model state
    int m_arm = 0, m_busy = 0, m_stall = 0;
    logic [7:0] m_addr = 0, m_data = 0, m_waddr = 0, m_wbyte = 0;
    logic [7:0] m_mem [int];

    eeacc_access_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (sel),
        .bus_we    (we),
        .bus_wdata (wd),
        .bus_rdata (rdata),
        .cpu_stall (stall)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WDOG);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_rdata(input logic [1:0] s);
        case (s)
            2'd0: return m_addr;
            2'd1: return m_data;
            2'd2: return {5'b0, m_arm > 0, m_busy > 0, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_update(input logic [1:0] s, input logic w, input logic [7:0] d);
        bit start, rd, abort, cw;
        if (!rst_n) begin
            m_arm = 0; m_busy = 0; m_stall = 0; m_addr = 0; m_data = 0;
            return;
        end
        cw    = w && (s == 2'd2);
        start = cw && d[1] && (m_arm > 0) && (m_busy == 0);
        rd    = cw && d[0] && (m_busy == 0) && !start;
        abort = w && (s < 2'd2) && (m_busy > 0);
        if (rd) m_data = m_mem.exists(int'(m_addr)) ? m_mem[int'(m_addr)] : 8'hxx;
        if (w && s == 2'd0) m_addr = d & 8'h3F;
        if (w && s == 2'd1) m_data = d;
        if (abort) begin
            m_mem[int'(m_waddr)] = 8'hFF;
            m_busy = 0;
        end else if (start) begin
            m_busy = WC; m_waddr = m_addr; m_wbyte = m_data;
        end else if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) m_mem[int'(m_waddr)] = m_wbyte;
        end
        if (start) m_arm = 0;
        else if (cw && d[2]) m_arm = 4;
        else if (m_arm > 0) m_arm--;
        if (start) m_stall = 2;
        else if (rd) m_stall = 4;
        else if (m_stall > 0) m_stall--;
    endtask

    // one bus cycle: drive at negedge, compare model, update model at posedge
    task automatic step(input logic [1:0] s, input logic w, input logic [7:0] d);
        @(negedge clk);
        sel = s; we = w; wd = d;
        #1;
        o_rd = rdata;
        o_st = stall;
        if (rst_n) begin
            chk("R1 model rdata", o_rd, m_rdata(s));
            chk("R5_R6 model stall", o_st, m_stall > 0);
        end
        @(posedge clk);
        m_update(s, w, d);
    endtask

    task automatic rd(input logic [1:0] s);
        step(s, 1'b0, 8'h00);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            rd(2'd2);
            if (o_rd[1] == 1'b0) break;
        end
    endtask

    task automatic read_byte(input logic [7:0] a);
        step(2'd0, 1'b1, a);
        step(2'd2, 1'b1, 8'h01);
        rd(2'd1);
    endtask

    initial begin
        int n;
        repeat (3) rd(2'd3);
        rst_n = 1'b1;

        // R9: reset state
        rd(2'd2);
        chk("R9 ctrl after reset", o_rd, 8'h00);
        chk("R9 stall after reset", o_st, 1'b0);

        // R1 address masking, R2 basic arm+strobe, R4 timing, R5 stall
        step(2'd0, 1'b1, 8'h45);
        rd(2'd0);
        chk("R1 address masked", o_rd, 8'h05);
        step(2'd1, 1'b1, 8'hA5);
        step(2'd2, 1'b1, 8'h04);
        step(2'd2, 1'b1, 8'h02);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            rd(2'd2);
            if (i < 2) chk("R5 write stall on", o_st, 1'b1);
            if (i == 2) chk("R5 write stall off", o_st, 1'b0);
            if (o_rd[1] == 1'b0) break;
            n++;
        end
        chk("R4 busy cycles", n, WC);
        read_byte(8'h05);
        chk("R6 read loads byte", o_rd, 8'hA5);
        chk("R6 read stall", o_st, 1'b1);
        rd(2'd2);
        chk("R6 read strobe bit reads 0", o_rd[0], 1'b0);
        rd(2'd3);
        chk("R1 select 3 reads zero", o_rd, 8'h00);

        // R2: both bits in one write only arms
        step(2'd2, 1'b1, 8'h06);
        rd(2'd2);
        chk("R2 same write only arms", o_rd, 8'h04);
        repeat (5) rd(2'd3);

        // R3: enable lapse timing
        step(2'd2, 1'b1, 8'h04);
        for (int i = 0; i < 4; i++) begin
            rd(2'd2);
            chk("R3 enable held", o_rd, 8'h04);
        end
        rd(2'd2);
        chk("R3 enable lapsed", o_rd, 8'h00);

        // R2: strobe five cycles after arming is too late
        step(2'd2, 1'b1, 8'h04);
        repeat (4) rd(2'd3);
        step(2'd2, 1'b1, 8'h02);
        rd(2'd2);
        chk("R2 late strobe rejected", o_rd, 8'h00);

        // R2: strobe four cycles after arming is accepted
        step(2'd0, 1'b1, 8'h09);
        step(2'd1, 1'b1, 8'h5A);
        step(2'd2, 1'b1, 8'h04);
        repeat (3) rd(2'd3);
        step(2'd2, 1'b1, 8'h02);
        rd(2'd2);
        chk("R2 strobe at edge of window", o_rd, 8'h02);
        wait_done();
        read_byte(8'h09);
        chk("R4 byte stored", o_rd, 8'h5A);

        // R7: abort by data register write
        step(2'd0, 1'b1, 8'h07);
        step(2'd1, 1'b1, 8'h3C);
        step(2'd2, 1'b1, 8'h04);
        step(2'd2, 1'b1, 8'h02);
        repeat (3) rd(2'd3);
        step(2'd1, 1'b1, 8'h11);
        rd(2'd2);
        chk("R7 abort clears busy", o_rd, 8'h00);
        rd(2'd1);
        chk("R7 data register takes new value", o_rd, 8'h11);
        step(2'd2, 1'b1, 8'h01);
        rd(2'd1);
        chk("R7 aborted byte poisoned", o_rd, 8'hFF);
        repeat (5) rd(2'd3);

        // R8: read strobe ignored while busy
        step(2'd1, 1'b1, 8'h77);
        step(2'd0, 1'b1, 8'h09);
        step(2'd2, 1'b1, 8'h04);
        step(2'd2, 1'b1, 8'h02);
        repeat (3) rd(2'd3);
        step(2'd2, 1'b1, 8'h01);
        rd(2'd1);
        chk("R8 data register unchanged", o_rd, 8'h77);
        chk("R8 no stall added", o_st, 1'b0);
        wait_done();
        read_byte(8'h09);
        chk("R8 write completed", o_rd, 8'h77);
        repeat (5) rd(2'd3);

        // R10: arm and strobe mid-write do not restart
        step(2'd0, 1'b1, 8'h0A);
        step(2'd1, 1'b1, 8'hC3);
        step(2'd2, 1'b1, 8'h04);
        step(2'd2, 1'b1, 8'h02);
        repeat (5) rd(2'd3);
        step(2'd2, 1'b1, 8'h04);
        step(2'd2, 1'b1, 8'h02);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            rd(2'd2);
            if (o_rd[1] == 1'b0) break;
            n++;
        end
        chk("R10 busy not extended", n, WC - 7);
        read_byte(8'h0A);
        chk("R10 original byte stored", o_rd, 8'hC3);
        repeat (5) rd(2'd3);

        // R9: reset keeps array, clears registers
        rst_n = 1'b0;
        repeat (2) rd(2'd3);
        rst_n = 1'b1;
        rd(2'd0);
        chk("R9 address cleared", o_rd, 8'h00);
        rd(2'd1);
        chk("R9 data cleared", o_rd, 8'h00);
        read_byte(8'h05);
        chk("R9 array retained", o_rd, 8'hA5);
        repeat (6) rd(2'd3);

        summary();
    end

endmodule